// File: doc/BRIEF.md
# Linked Schedule Sequencer for Two Pipelines

This block walks a small on-chip table of schedule slots, one slot per clock, and on every cycle it produces a stream number for each of two independent communication pipelines. The order of the walk is not fixed by a counter. Each slot stores the index of the slot to read after it, so the stored links close the walk into a loop of any length up to the table depth. When the two pipelines need different periods, the loop is written with the least common multiple of the two periods, and the sequencer just follows the links.

The table is filled through a load port while the sequencer is halted, normally at boot. A start index is set, and then `run` is raised. From then on the block emits one valid pair of stream numbers per cycle until `run` falls. Raising `run` again restarts the walk at the start index.

Top module: `sched_seq`

## Requirements
- R1: While reset is applied and after it is released, `strm_vld` is low and both stream outputs are zero until a run begins.
- R2: A load writes `ld_data` into slot `ld_addr` when `ld_we` is high and `run` is low. The slot layout is stream for pipeline A in bits [4:0], stream for pipeline B in bits [9:5], and the next-slot index in bits [16:10].
- R3: If `run` is high at a clock edge while the sequencer is idle, the pointer loads `start_idx`. The stream pair of that slot appears with `strm_vld` high one clock later.
- R4: While `run` stays high, every following cycle presents the slot named by the next-index field of the slot shown in the cycle before.
- R5: A slot whose next-index equals its own index gives the same stream pair on every cycle for as long as `run` stays high.
- R6: A closed loop of links repeats without end. A loop whose length is the least common multiple of two pipeline periods gives each pipeline its own period.
- R7: A load attempted while `run` is high leaves the table unchanged.
- R8: One clock after `run` is sampled low, `strm_vld` is low. A later rise of `run` restarts the walk at the current `start_idx`.
- R9: Any stream value from 0 to 31 can be given on either pipeline in any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High to sequence, low to halt and allow loads |
| start_idx | input | 7 | Slot where a run begins |
| ld_we | input | 1 | Load write enable |
| ld_addr | input | 7 | Slot written by a load |
| ld_data | input | 17 | Slot contents: next index, stream B, stream A |
| strm_a | output | 5 | Stream number for pipeline A |
| strm_b | output | 5 | Stream number for pipeline B |
| strm_vld | output | 1 | High when the stream outputs hold a scheduled slot |

## Verification
The hardest case to reach from the ports is a load that arrives while a run is in progress. The table cannot be read back directly, so its effect shows only in a later walk. The stimulus pulses `ld_we` at a slot on the active loop in the middle of a run. It then halts and restarts the run from that slot and expects the old stream pair. A loop of length six, whose pipeline A values repeat every two slots and pipeline B values every three, exercises the least-common-multiple case. A self-linked slot exercises the one-slot loop.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int unsigned IDX_W  = 7;
  parameter int unsigned STRM_W = 5;
  localparam int unsigned ENT_W = IDX_W + 2 * STRM_W;

  typedef struct packed {
    logic [IDX_W-1:0]  nxt;
    logic [STRM_W-1:0] sb;
    logic [STRM_W-1:0] sa;
  } slot_t;
endpackage

// File: rtl/sched_store.sv
module sched_store
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  slot_t            wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output slot_t            q,
  output logic             q_vld
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  slot_t mem [DEPTH];
  slot_t q_r, q_d;
  logic  vld_r, vld_d;

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    q_d   = q_r;
    vld_d = rd_en;
    if (rd_en) q_d = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      vld_r <= 1'b0;
    end else begin
      q_r   <= q_d;
      vld_r <= vld_d;
    end
  end

  assign q     = q_r;
  assign q_vld = vld_r;
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] link,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic [IDX_W-1:0] cur_idx
);
  logic             active_q, active_d;
  logic             first_q, first_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;

  assign rd_en   = run && active_q;
  assign rd_addr = first_q ? ptr_q : link;
  assign cur_idx = ptr_q;

  always_comb begin
    active_d = active_q;
    first_d  = first_q;
    ptr_d    = ptr_q;
    if (!run) begin
      active_d = 1'b0;
      first_d  = 1'b0;
    end else if (!active_q) begin
      active_d = 1'b1;
      first_d  = 1'b1;
      ptr_d    = start_idx;
    end else begin
      first_d  = 1'b0;
      ptr_d    = rd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      ptr_q    <= '0;
    end else begin
      active_q <= active_d;
      first_q  <= first_d;
      ptr_q    <= ptr_d;
    end
  end

  // R3: an idle-to-run edge arms the pointer at the start slot
  p_arm_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !active_q) |=> (active_q && first_q && ptr_q == $past(start_idx)));
endmodule

// File: rtl/sched_seq.sv
module sched_seq
  import sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_addr,
  input  logic [ENT_W-1:0]  ld_data,
  output logic [STRM_W-1:0] strm_a,
  output logic [STRM_W-1:0] strm_b,
  output logic              strm_vld
);
  logic [1:0]       rs_q;
  logic             rst_i;
  logic             rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [IDX_W-1:0] cur_idx;
  logic             wr_ok;
  slot_t            q;
  logic             q_vld;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign wr_ok = ld_we && !run;

  sched_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i), .run(run), .start_idx(start_idx),
    .link(q.nxt), .rd_en(rd_en), .rd_addr(rd_addr), .cur_idx(cur_idx)
  );

  sched_store u_store (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_ok), .wr_addr(ld_addr),
    .wr_data(slot_t'(ld_data)), .rd_en(rd_en), .rd_addr(rd_addr),
    .q(q), .q_vld(q_vld)
  );

  assign strm_a   = q.sa;
  assign strm_b   = q.sb;
  assign strm_vld = q_vld;

  // R4: back-to-back slots follow the stored link
  p_follow_link_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (strm_vld && $past(strm_vld)) |-> (cur_idx == $past(q.nxt)));

  // R5: a self-linked slot holds its pair while running
  p_self_hold_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (strm_vld && run && q.nxt == cur_idx) |=> (strm_vld && $stable(strm_a) && $stable(strm_b)));

  // R8: halting drops valid one edge later
  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_i)
    !run |=> !strm_vld);
endmodule

// File: tb/sched_seq_bench.sv
module sched_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [6:0]  start_idx = '0;
  logic        ld_we = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [16:0] ld_data = '0;
  logic [4:0]  strm_a, strm_b;
  logic        strm_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit live = 1'b0;
  logic [16:0] model [128];
  logic [9:0]  exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  sched_seq u_sched_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .start_idx(start_idx),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .strm_a(strm_a), .strm_b(strm_b), .strm_vld(strm_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected pairs as valid slots appear
  always @(negedge clk) begin
    if (live && strm_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected valid", 1, 0);
      else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({strm_b, strm_a} == e, t, int'({strm_b, strm_a}), int'(e));
      end
    end
  end

  task automatic load(input int a, input int sa, input int sb, input int nx);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 7'(a);
    ld_data = {7'(nx), 5'(sb), 5'(sa)};
    if (!run) model[a] = ld_data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run_sched(input int st, input int n, input string tag,
                           input bit wr, input int wa, input logic [16:0] wd);
    int idx;
    idx = st;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[idx][9:0]);
      tag_q.push_back(tag);
      idx = int'(model[idx][16:10]);
    end
    @(negedge clk);
    start_idx = 7'(st); run = 1'b1;
    for (int k = 0; k < n + 1; k++) begin
      @(negedge clk);
      if (wr && k == 0) begin ld_we = 1'b1; ld_addr = 7'(wa); ld_data = wd; end
      if (k == 1) ld_we = 1'b0;
    end
    run = 1'b0;
    @(negedge clk);
    chk(strm_vld == 1'b0, "R8 valid low after halt", int'(strm_vld), 0);
    chk(exp_q.size() == 0, "R4 all slots seen", exp_q.size(), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strm_vld == 1'b0, "R1 valid in reset", int'(strm_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(strm_vld == 1'b0, "R1 valid after reset", int'(strm_vld), 0);
    chk(strm_a == 5'd0, "R1 stream A zero", int'(strm_a), 0);
    chk(strm_b == 5'd0, "R1 stream B zero", int'(strm_b), 0);
    live = 1'b1;

    // three-slot loop with extreme stream values (R9)
    load(10, 3, 17, 20);
    load(20, 31, 0, 30);
    load(30, 0, 31, 10);
    run_sched(10, 7, "R3 R4 R9 loop walk", 1'b0, 0, '0);

    // one-slot loop
    load(5, 12, 25, 5);
    run_sched(5, 4, "R5 self link", 1'b0, 0, '0);

    // period 2 on A, period 3 on B, loop of 6
    for (int i = 0; i < 6; i++) load(40 + i, 1 + i % 2, 7 + i % 3, 40 + (i + 1) % 6);
    run_sched(40, 14, "R6 lcm loop", 1'b0, 0, '0);

    // load during a run is ignored, then seen unchanged
    run_sched(10, 3, "R7 write while running", 1'b1, 10, {7'd10, 5'd9, 5'd9});
    run_sched(10, 3, "R7 table unchanged", 1'b0, 0, '0);

    // restart at other start slots
    run_sched(20, 2, "R8 restart at 20", 1'b0, 0, '0);
    run_sched(30, 2, "R8 restart at 30", 1'b0, 0, '0);

    // load while halted takes effect
    load(10, 4, 5, 30);
    run_sched(10, 3, "R2 halted load", 1'b0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule